// File: doc/BRIEF.md
# Serial Loader Entry and Bit-Rate Lock

This block sits at the front of a serial program loader. It watches the reset pin, the active-low program-store-enable strobe and two high select pins of an I/O port. From these it decides whether the device has been put into serial loading mode. If the select pins point at any other load path, it stays out of the way.

Once in loading mode, the block waits for a host terminal to send a carriage return. It times the opening low/high/low pattern of that character and picks the nearest of four fixed bit rates. It then resamples the rest of the character at the chosen rate, and locks only when the whole character checks out. After lock, every further character is received at mid-bit with one stop bit. A character that names a loader command produces a one-cycle strobe and a compact command code for the command interpreter downstream.

All bit timing is expressed in clock cycles. `BASE_CYCLES` is the bit period of the fastest rate, and the slower rates are fixed multiples of it.

Top module: `sload_front`

## Requirements
- R1: With the reset pin high, the strobe low and both select pins high at the same time, `load_mode` reads 1 three clock edges after the pins change (two synchroniser stages plus one register). With the reset pin low it never rises.
- R2: With any select value other than 2'b11 (2'b00, 2'b01, 2'b10), `load_mode` stays 0 even while the reset pin is high and the strobe is low.
- R3: `load_mode` stays set after the strobe is released, as long as the reset pin stays high. Dropping the reset pin clears `load_mode` and `rate_locked`, and no command strobe appears until the block is entered again.
- R4: A carriage return (0x0D, 8N1, LSB first) sent with a bit period of BASE_CYCLES×1, ×4, ×8 or ×32 gives `rate_locked`=1 with `rate_idx` 0, 1, 2 or 3 respectively (9600, 2400, 1200 and 300 bit/s).
- R5: The span from the start-bit falling edge to the rising edge that ends data bit 1 (three bit periods) must lie within ±12 % of the nominal span of one rate. A span 7 % long still locks. A span 25 % long gives no lock, and detection restarts so that a later good carriage return locks.
- R6: After the span matches, data bits 2 to 7 and the stop bit are sampled at mid-bit at the nominal period. They must read 1,1,0,0,0,0 and a high stop bit, otherwise the block does not lock and restarts. For example, 0x2D at a valid rate does not lock.
- R7: After lock, a received character with a high stop bit produces a one-cycle `cmd_valid` and a `cmd_code` as follows: 'C'=0, 'D'=1, 'F'=2, 'G'=3, 'K'=4, 'L'=5, 'P'=6, 'R'=7, 'T'=8, 'U'=9, 'V'=10, 'W'=11, 'Z'=12 (upper-case ASCII only).
- R8: Any other character, including lower case, 'A', digits and 0x0D, produces no strobe.
- R9: A character whose stop bit samples low is dropped without a strobe, and the next well-formed character is received normally.
- R10: Once locked, `rate_idx` and `rate_locked` keep their values until loading mode is left. A further carriage return, even at another rate, is never taken as a new rate.
- R11: After the synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| pin_reset | input | 1 | Device reset pin, active high, asynchronous |
| pin_strobe_n | input | 1 | Program-store-enable pin, active low, asynchronous |
| pin_sel | input | 2 | Port 2 bits 7 and 6, bit 1 = bit 7 |
| rxd | input | 1 | Serial receive line, idle high |
| load_mode | output | 1 | Serial loading mode active |
| rate_idx | output | 2 | Locked rate: 0=9600, 1=2400, 2=1200, 3=300 bit/s |
| rate_locked | output | 1 | Bit rate detected and confirmed |
| cmd_valid | output | 1 | One-cycle strobe for a recognised command |
| cmd_code | output | 4 | Code of the last recognised command |

## Verification
The assertions assume that the receive line idles high and carries 8N1 characters. They also assume that a failed detection attempt is followed by an idle gap longer than the slowest rate's measurement window, so that the timeout can return the detector to its hunt state. The pins are taken to change far more slowly than the clock, so that the two-stage synchroniser passes each level cleanly. The stimulus drives every input a few nanoseconds after a rising edge. It leaves at least 2000 idle cycles after each rejected span and holds each pin setting for several cycles before looking at the outputs.

// File: rtl/sload_pkg.sv
package sload_pkg;

  localparam int NUM_RATES = 4;
  localparam int RATE_W    = $clog2(NUM_RATES);
  localparam int CMD_W     = 4;

  // bit period of each rate as a multiple of the fastest one
  function automatic int rate_mult(input int idx);
    case (idx)
      0:       return 1;   // 9600
      1:       return 4;   // 2400
      2:       return 8;   // 1200
      default: return 32;  // 300
    endcase
  endfunction

  typedef struct packed {
    logic             hit;
    logic [CMD_W-1:0] code;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [7:0] ch);
    cmd_dec_t d;
    d.hit  = 1'b1;
    d.code = '0;
    case (ch)
      8'h43:   d.code = 4'd0;   // C
      8'h44:   d.code = 4'd1;   // D
      8'h46:   d.code = 4'd2;   // F
      8'h47:   d.code = 4'd3;   // G
      8'h4B:   d.code = 4'd4;   // K
      8'h4C:   d.code = 4'd5;   // L
      8'h50:   d.code = 4'd6;   // P
      8'h52:   d.code = 4'd7;   // R
      8'h54:   d.code = 4'd8;   // T
      8'h55:   d.code = 4'd9;   // U
      8'h56:   d.code = 4'd10;  // V
      8'h57:   d.code = 4'd11;  // W
      8'h5A:   d.code = 4'd12;  // Z
      default: d.hit  = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sload_sync.sv
module sload_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= INIT;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/sload_entry.sv
module sload_entry (
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_pin_s,
  input  logic       strobe_n_s,
  input  logic [1:0] sel_s,
  output logic       load_mode,
  output logic       active_nxt
);

  // next value of the mode flag; also the clear for the downstream logic
  always_comb begin
    active_nxt = load_mode;
    if (!strobe_n_s && sel_s == 2'b11) active_nxt = 1'b1;
    if (!rst_pin_s || rst)             active_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) load_mode <= 1'b0;
    else     load_mode <= active_nxt;
  end

  AST_EXIT_ON_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    !rst_pin_s |=> !load_mode) else $error("mode kept with reset pin low"); // R3

endmodule

// File: rtl/sload_rate_det.sv
module sload_rate_det
  import sload_pkg::*;
#(
  parameter int BASE_CYCLES = 16,
  parameter int TOL_PCT     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              rxd_s,
  output logic              locked,
  output logic [RATE_W-1:0] rate_idx
);

  localparam int SPAN_MAX = 3 * BASE_CYCLES * rate_mult(NUM_RATES-1);
  localparam int HI_MAX   = SPAN_MAX + SPAN_MAX * TOL_PCT / 100;
  localparam int CW       = $clog2(HI_MAX + 2);
  localparam logic [6:0] TAIL_OK = 7'b1000011; // stop,b7..b2 of 0x0D

  typedef enum logic [2:0] {D_HUNT, D_LOW0, D_HIGH, D_LOW1, D_CHECK, D_DONE} dstate_t;

  dstate_t           st;
  logic [CW-1:0]     cnt;
  logic              rx_prev;
  logic [RATE_W-1:0] cand;
  logic [6:0]        sh;
  logic [2:0]        nbit;
  logic [NUM_RATES-1:0] hit;
  logic [RATE_W-1:0] hit_idx;
  logic [CW-1:0]     per_tab [NUM_RATES];
  logic [CW-1:0]     meas;
  logic [6:0]        sh_nxt;
  logic              fall, rise;

  assign fall   = rx_prev & ~rxd_s;
  assign rise   = ~rx_prev & rxd_s;
  assign meas   = cnt + CW'(1);
  assign sh_nxt = {rxd_s, sh[6:1]};

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam int PER  = BASE_CYCLES * rate_mult(g);
    localparam int SPAN = 3 * PER;
    localparam int LO   = SPAN - SPAN * TOL_PCT / 100;
    localparam int HI   = SPAN + SPAN * TOL_PCT / 100;
    assign per_tab[g] = CW'(PER);
    assign hit[g]     = (meas >= CW'(LO)) && (meas <= CW'(HI));
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_RATES; i++) if (hit[i]) hit_idx = RATE_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      st <= D_HUNT; cnt <= '0; rx_prev <= 1'b1; cand <= '0;
      sh <= '0; nbit <= '0; locked <= 1'b0; rate_idx <= '0;
    end else begin
      rx_prev <= rxd_s;
      case (st)
        D_HUNT: if (fall) begin st <= D_LOW0; cnt <= '0; end
        D_LOW0, D_HIGH, D_LOW1: begin
          if (cnt == CW'(HI_MAX)) st <= D_HUNT;   // no edge in time
          else begin
            cnt <= cnt + CW'(1);
            if (st == D_LOW0 && rise) st <= D_HIGH;
            if (st == D_HIGH && fall) st <= D_LOW1;
            if (st == D_LOW1 && rise) begin
              if (|hit) begin
                cand <= hit_idx;
                cnt  <= (per_tab[hit_idx] >> 1) - CW'(1);
                nbit <= '0;
                st   <= D_CHECK;
              end else st <= D_HUNT;
            end
          end
        end
        D_CHECK: begin
          if (cnt != '0) cnt <= cnt - CW'(1);
          else begin
            sh  <= sh_nxt;
            cnt <= per_tab[cand] - CW'(1);
            if (nbit == 3'd6) begin
              if (sh_nxt == TAIL_OK) begin
                locked <= 1'b1; rate_idx <= cand; st <= D_DONE;
              end else st <= D_HUNT;
            end else nbit <= nbit + 3'd1;
          end
        end
        default: st <= D_DONE;
      endcase
    end
  end

  AST_LOCK_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(rxd_s)) else $error("lock without high stop bit"); // R6
  AST_IDX_STABLE: assert property (@(posedge clk) disable iff (rst)
    locked && $past(locked) |-> $stable(rate_idx)) else $error("rate moved while locked"); // R10

endmodule

// File: rtl/sload_cmd_rx.sv
module sload_cmd_rx
  import sload_pkg::*;
#(
  parameter int BASE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              locked,
  input  logic              rxd_s,
  input  logic [RATE_W-1:0] rate_idx,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code
);

  localparam int PER_MAX = BASE_CYCLES * rate_mult(NUM_RATES-1);
  localparam int TW      = $clog2(PER_MAX + 1);

  typedef enum logic [1:0] {C_IDLE, C_START, C_DATA, C_STOP} cstate_t;

  cstate_t       st;
  logic [TW-1:0] tmr;
  logic [2:0]    nbit;
  logic [7:0]    sh;
  logic          rx_prev;
  logic [TW-1:0] per_tab [NUM_RATES];
  logic [TW-1:0] per;
  cmd_dec_t      dec;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_per
    assign per_tab[g] = TW'(BASE_CYCLES * rate_mult(g));
  end

  assign per = per_tab[rate_idx];
  assign dec = decode_cmd(sh);

  always_ff @(posedge clk) begin
    if (rst || !active || !locked) begin
      st <= C_IDLE; tmr <= '0; nbit <= '0; sh <= '0; rx_prev <= 1'b1;
      cmd_valid <= 1'b0; cmd_code <= '0;
    end else begin
      rx_prev   <= rxd_s;
      cmd_valid <= 1'b0;
      case (st)
        C_IDLE: if (rx_prev && !rxd_s) begin
          tmr <= (per >> 1) - TW'(1); st <= C_START;
        end
        C_START: begin
          if (tmr != '0) tmr <= tmr - TW'(1);
          else if (rxd_s) st <= C_IDLE;            // glitch, not a start bit
          else begin tmr <= per - TW'(1); nbit <= '0; st <= C_DATA; end
        end
        C_DATA: begin
          if (tmr != '0) tmr <= tmr - TW'(1);
          else begin
            sh  <= {rxd_s, sh[7:1]};
            tmr <= per - TW'(1);
            if (nbit == 3'd7) st <= C_STOP;
            else nbit <= nbit + 3'd1;
          end
        end
        default: begin
          if (tmr != '0) tmr <= tmr - TW'(1);
          else begin
            st <= C_IDLE;
            if (rxd_s && dec.hit) begin
              cmd_valid <= 1'b1;
              cmd_code  <= dec.code;
            end
          end
        end
      endcase
    end
  end

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid) else $error("strobe longer than one cycle"); // R7
  AST_CMD_RANGE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_code <= CMD_W'(12)) else $error("code out of range"); // R7
  AST_CMD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> locked) else $error("strobe without lock"); // R10
  AST_CMD_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(rxd_s)) else $error("strobe after low stop bit"); // R9

endmodule

// File: rtl/sload_front.sv
module sload_front
  import sload_pkg::*;
#(
  parameter int BASE_CYCLES = 16,
  parameter int TOL_PCT     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_reset,
  input  logic              pin_strobe_n,
  input  logic [1:0]        pin_sel,
  input  logic              rxd,
  output logic              load_mode,
  output logic [RATE_W-1:0] rate_idx,
  output logic              rate_locked,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code
);

  logic [4:0] raw, syn;
  logic       active_nxt;

  assign raw = {pin_reset, pin_strobe_n, pin_sel, rxd};

  sload_sync #(.W(5), .STAGES(SYNC_STAGES), .INIT(5'b01001)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  sload_entry u_entry (
    .clk(clk), .rst(rst),
    .rst_pin_s(syn[4]), .strobe_n_s(syn[3]), .sel_s(syn[2:1]),
    .load_mode(load_mode), .active_nxt(active_nxt)
  );

  sload_rate_det #(.BASE_CYCLES(BASE_CYCLES), .TOL_PCT(TOL_PCT)) u_det (
    .clk(clk), .rst(rst), .active(active_nxt), .rxd_s(syn[0]),
    .locked(rate_locked), .rate_idx(rate_idx)
  );

  sload_cmd_rx #(.BASE_CYCLES(BASE_CYCLES)) u_cmd (
    .clk(clk), .rst(rst), .active(active_nxt), .locked(rate_locked),
    .rxd_s(syn[0]), .rate_idx(rate_idx),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  AST_ENTRY_PINS: assert property (@(posedge clk) disable iff (rst)
    $rose(load_mode) |-> $past(pin_reset, 3) && !$past(pin_strobe_n, 3) && ($past(pin_sel, 3) == 2'b11))
    else $error("mode entered without entry pins"); // R1
  AST_LOCK_IN_MODE: assert property (@(posedge clk) disable iff (rst)
    rate_locked |-> load_mode) else $error("lock outside loading mode"); // R3

endmodule

// File: tb/sload_front_tb.sv
module sload_front_tb;
  import sload_pkg::*;

  localparam int BASE = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_reset = 1'b0;
  logic       pin_strobe_n = 1'b1;
  logic [1:0] pin_sel = 2'b00;
  logic       rxd = 1'b1;
  logic       load_mode, rate_locked, cmd_valid;
  logic [1:0] rate_idx;
  logic [3:0] cmd_code;

  always #5 clk = ~clk;

  sload_front #(.BASE_CYCLES(BASE)) u_dut (
    .clk(clk), .rst(rst), .pin_reset(pin_reset), .pin_strobe_n(pin_strobe_n),
    .pin_sel(pin_sel), .rxd(rxd), .load_mode(load_mode), .rate_idx(rate_idx),
    .rate_locked(rate_locked), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  int  got[$];

  // behavioural model of the mode flag, advanced once per clock
  bit       m_r1, m_r2, m_n1 = 1, m_n2 = 1, m_lm;
  bit [1:0] m_s1, m_s2;

  always @(negedge clk) begin
    total++;
    if (load_mode !== m_lm) begin
      bad++;
      $display("FAIL R1 R3 load_mode actual=%0b expected=%0b t=%0t", load_mode, m_lm, $time);
    end
    if (!m_lm && (rate_locked !== 1'b0 || cmd_valid !== 1'b0)) begin
      bad++;
      $display("FAIL R3 outside mode locked=%0b strobe=%0b expected=0 t=%0t", rate_locked, cmd_valid, $time);
    end
    if (cmd_valid === 1'b1) got.push_back(int'(cmd_code));
    if (rst) begin
      m_lm = 0; m_r1 = 0; m_r2 = 0; m_n1 = 1; m_n2 = 1; m_s1 = 0; m_s2 = 0;
    end else begin
      if (!m_r2) m_lm = 0;
      else if (!m_n2 && m_s2 == 2'b11) m_lm = 1;
      m_r2 = m_r1; m_n2 = m_n1; m_s2 = m_s1;
      m_r1 = pin_reset; m_n1 = pin_strobe_n; m_s1 = pin_sel;
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input int per, input logic stopv);
    rxd = 1'b0; step(per);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; step(per); end
    rxd = stopv; step(per);
    rxd = 1'b1;
  endtask

  task automatic expect_cmd(input string req, input int code);
    total++;
    if (got.size() != 1 || got[0] != code) begin
      bad++;
      $display("FAIL %s actual_count=%0d actual_code=%0d expected_code=%0d",
               req, got.size(), (got.size() > 0) ? got[0] : -1, code);
    end
    got.delete();
  endtask

  task automatic expect_none(input string req);
    total++;
    if (got.size() != 0) begin
      bad++;
      $display("FAIL %s actual_count=%0d expected_count=0", req, got.size());
    end
    got.delete();
  endtask

  task automatic enter();
    pin_reset = 1'b1; pin_strobe_n = 1'b0; pin_sel = 2'b11;
    step(5);
    pin_strobe_n = 1'b1; pin_sel = 2'b00;
    step(2);
  endtask

  task automatic leave();
    pin_reset = 1'b0; step(5);
    chk(load_mode == 1'b0 && rate_locked == 1'b0, "R3 exit", int'(rate_locked), 0);
    got.delete();
  endtask

  task automatic lock_at(input int per, input int idx, input string req);
    send(8'h0D, per, 1'b1); step(4);
    chk(rate_locked == 1'b1, req, int'(rate_locked), 1);
    chk(int'(rate_idx) == idx, req, int'(rate_idx), idx);
  endtask

  initial begin
    string cmds;
    string rate_cmd;
    cmds     = "CDFGKLPRTUVWZ";
    rate_cmd = "CLVZ";
    step(4);
    rst = 1'b0;
    step(1);
    // R11 reset state
    chk(load_mode == 0 && rate_locked == 0 && cmd_valid == 0, "R11 flags", int'(load_mode), 0);
    chk(rate_idx == 0 && cmd_code == 0, "R11 fields", int'(rate_idx), 0);

    // R2 other select values
    pin_reset = 1'b1; pin_strobe_n = 1'b0;
    for (int s = 0; s < 3; s++) begin
      pin_sel = 2'(s); step(6);
      chk(load_mode == 1'b0, "R2", int'(load_mode), 0);
    end
    // R1 reset pin low blocks entry
    pin_reset = 1'b0; pin_sel = 2'b11; step(6);
    chk(load_mode == 1'b0, "R1 no reset", int'(load_mode), 0);
    // R1 exact latency
    pin_reset = 1'b1; step(2);
    chk(load_mode == 1'b0, "R1 before edge 3", int'(load_mode), 0);
    step(1);
    chk(load_mode == 1'b1, "R1 edge 3", int'(load_mode), 1);
    // R3 held after strobe release
    pin_strobe_n = 1'b1; pin_sel = 2'b00; step(10);
    chk(load_mode == 1'b1, "R3 held", int'(load_mode), 1);
    leave();

    // R4 each rate, then one command at that rate (R7)
    for (int r = 3; r >= 0; r--) begin
      enter();
      lock_at(BASE * rate_mult(r), r, "R4");
      send(rate_cmd[r], BASE * rate_mult(r), 1'b1); step(4);
      case (r)
        0: expect_cmd("R7 slowpath C", 0);
        1: expect_cmd("R7 slowpath L", 5);
        2: expect_cmd("R7 slowpath V", 10);
        default: expect_cmd("R7 slowpath Z", 12);
      endcase
      leave();
    end

    // R5 tolerance
    enter();
    lock_at(137, 2, "R5 seven percent long");
    leave();
    enter();
    send(8'h0D, 20, 1'b1); step(2000);
    chk(rate_locked == 1'b0, "R5 25 percent long", int'(rate_locked), 0);
    lock_at(BASE, 0, "R5 restart");
    leave();

    // R6 tail must confirm 0x0D
    enter();
    send(8'h2D, BASE * 4, 1'b1); step(10);
    chk(rate_locked == 1'b0, "R6 wrong tail", int'(rate_locked), 0);
    lock_at(BASE * 4, 1, "R6 recover");
    leave();

    // R7 full command map at the fastest rate
    enter();
    lock_at(BASE, 0, "R4 fast");
    for (int i = 0; i < 13; i++) begin
      send(cmds[i], BASE, 1'b1); step(4);
      expect_cmd("R7 map", i);
    end
    // R8 rejected characters
    send(8'h63, BASE, 1'b1); step(4); expect_none("R8 lower c");
    send(8'h41, BASE, 1'b1); step(4); expect_none("R8 A");
    send(8'h30, BASE, 1'b1); step(4); expect_none("R8 digit");
    send(8'h0D, BASE, 1'b1); step(4); expect_none("R8 CR");
    // R9 framing error then recovery
    send(8'h4C, BASE, 1'b0); step(BASE);
    expect_none("R9 low stop");
    send(8'h4B, BASE, 1'b1); step(4);
    expect_cmd("R9 next char", 4);
    // R10 a slower CR does not relock
    send(8'h0D, BASE * 4, 1'b1); step(100);
    expect_none("R10 slow CR");
    chk(rate_locked == 1'b1, "R10 locked", int'(rate_locked), 1);
    chk(rate_idx == 2'd0, "R10 index", int'(rate_idx), 0);
    leave();
    send(8'h43, BASE, 1'b1); step(4);
    expect_none("R3 no strobe after exit");

    done = 1;
    finish_run();
  end

endmodule